// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the part of a bus target that answers an alert-response read. A host that sees the shared interrupt line go low reads from the general alert-response address. Every target that is holding its alert acknowledges that read and places its own address on the bus. Wired-AND arbitration on the data line decides which target is reported, and the lowest address wins. The block also owns the alert state. An alert-event pulse arms the responder, and arming drives the alert output. A response that is fully sent clears the alert.

The block sits after the SCL/SDA synchronisers and the START/STOP detectors of the target's bus front end. It drives only a pull-low enable for SDA. It does not handle normal register access.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset the responder is disarmed and `sda_pull` is 0. An `alert_event` pulse while no transaction is open arms it. `alert_out` is high exactly when the responder is armed and `mode_en` is 1.
- R2: SDA is pulled low during the ninth clock of the first byte only when that byte is 0x19 (address 0001100 followed by read bit 1), the responder is armed, and `mode_en` is 1. In every other case the responder never pulls SDA.
- R3: After the acknowledge, the responder sends 0xC9 (its address 1100100 followed by a 1), most significant bit first. Each bit is driven from the SCL falling edge that comes before the clock high period carrying it.
- R4: On an SCL rising edge, if the responder is sending a 1 but samples SDA low, it releases SDA for the rest of the transaction. The host then reads the lower, competing address.
- R5: A responder that loses arbitration stays armed and answers the next alert-response read.
- R6: When all eight response bits go out without a loss, the responder disarms. Later alert-response reads get no acknowledge until a new `alert_event` arrives.
- R7: An `alert_event` that arrives while a transaction is open is held. It arms the responder at the next START or STOP, even if that transaction has just disarmed it.
- R8: A STOP or START at any point ends the response and releases SDA. The armed state is left unchanged.
- R9: The host's acknowledge bit after the response byte is ignored. SDA is released during that ninth clock, and the outcome is the same for ACK and NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| start_det | input | 1 | One-cycle pulse on START or repeated START |
| stop_det | input | 1 | One-cycle pulse on STOP |
| alert_event | input | 1 | One-cycle pulse when a new alert condition occurs |
| mode_en | input | 1 | Alert mode enable |
| sda_pull | output | 1 | 1 pulls SDA low |
| alert_out | output | 1 | 1 asserts the shared alert line |

## Verification
First bytes of 0x19, 0x18 and random values separate the single address the responder answers from its near misses and from unrelated traffic. A competing target with a lower address, then one with a higher address, shows whether the responder drops out at the first losing bit and whether a loss keeps the alert while a win clears it. Transactions cut off by STOP inside the address byte and inside the response byte check that the responder releases SDA while keeping its armed state. An alert event injected mid-response checks the deferred re-arm. Random runs mix the alert event, `mode_en`, the competitor and the host's final ACK/NAK, and each run is compared with a bench model of wired-AND arbitration.

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter logic [6:0] DEV_ADDR = 7'b1100100,
  parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic start_det,
  input  logic stop_det,
  input  logic alert_event,
  input  logic mode_en,
  output logic sda_pull,
  output logic alert_out
);
  localparam logic [7:0] RESP  = {DEV_ADDR, 1'b1};
  localparam logic [7:0] MATCH = {ARA_ADDR, 1'b1};

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_ACK, ST_SEND, ST_HOLD} st_t;

  st_t        st;
  logic       scl_q;
  logic [7:0] rx, tx;
  logic [3:0] cnt;
  logic       armed, pend;

  wire scl_rise = scl_in & ~scl_q;
  wire scl_fall = ~scl_in & scl_q;
  wire bus_edge = start_det | stop_det;
  wire lose     = (st == ST_SEND) && scl_rise && tx[7] && !sda_in;
  wire win      = (st == ST_SEND) && scl_rise && !lose && (cnt == 4'd7);

  assign alert_out = armed & mode_en;

  always_ff @(posedge clk) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rx       <= '0;
      tx       <= '0;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      st       <= ST_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        ST_ADDR:
          if (scl_rise && cnt < 4'd8) begin
            rx  <= {rx[6:0], sda_in};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (rx == MATCH && armed && mode_en) begin
              st       <= ST_ACK;
              sda_pull <= 1'b1;
            end else begin
              st <= ST_HOLD;
            end
          end
        ST_ACK:
          if (scl_fall) begin
            st       <= ST_SEND;
            tx       <= RESP;
            cnt      <= '0;
            sda_pull <= ~RESP[7];
          end
        ST_SEND:
          if (lose || win) begin
            st       <= ST_HOLD;
            sda_pull <= 1'b0;
          end else if (scl_fall) begin
            tx       <= {tx[6:0], 1'b1};
            cnt      <= cnt + 4'd1;
            sda_pull <= ~tx[6];
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (bus_edge && pend) begin
        armed <= 1'b1;
        pend  <= 1'b0;
      end else if (win && !bus_edge) begin
        armed <= 1'b0;
      end
      if (alert_event) begin
        if (st == ST_IDLE && !bus_edge) armed <= 1'b1;
        else                            pend  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_alert_responder_chk.sv
module smb_alert_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_in,
  input logic       start_det,
  input logic       stop_det,
  input logic       alert_event,
  input logic       mode_en,
  input logic       sda_pull,
  input logic       alert_out,
  input logic [2:0] st,
  input logic       armed,
  input logic       pend,
  input logic       tx_msb
);
  localparam logic [2:0] S_IDLE = 3'd0, S_ACK = 3'd2, S_SEND = 3'd3, S_HOLD = 3'd4;

  logic scl_d;
  always_ff @(posedge clk) begin
    if (!rst_n) scl_d <= 1'b1;
    else        scl_d <= scl_in;
  end

  AST_ALERT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    alert_out |-> mode_en); // R1
  AST_EVENT_ARMS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_event && st == S_IDLE && !start_det && !stop_det) |=> armed); // R1
  AST_PULL_ONLY_RESPONDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (st == S_ACK || st == S_SEND)); // R2
  AST_ACK_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && st == S_ACK) |-> ($past(armed) && $past(mode_en))); // R2
  AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && scl_in && !scl_d && tx_msb && !sda_in && !start_det && !stop_det)
      |=> (!sda_pull && st == S_HOLD)); // R4
  AST_DISARM_ONLY_ON_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> ($past(st) == S_SEND)); // R6
  AST_PENDING_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && (start_det || stop_det)) |=> armed); // R7
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull && st == S_IDLE)); // R8
  AST_STOP_KEEPS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !pend && !alert_event) |=> $stable(armed)); // R8
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> !sda_pull); // R9
endmodule

bind smb_alert_responder smb_alert_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
  .start_det(start_det), .stop_det(stop_det), .alert_event(alert_event),
  .mode_en(mode_en), .sda_pull(sda_pull), .alert_out(alert_out),
  .st(st), .armed(armed), .pend(pend), .tx_msb(tx[7])
);

// File: tb/smb_alert_responder_test.sv
module smb_alert_responder_test;
  localparam int HP = 8;
  localparam logic [6:0] DEV = 7'b1100100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl, sda_m, comp_sda, start_det, stop_det, alert_event, mode_en;
  logic sda_pull, alert_out;
  wire  sda_line = sda_m & comp_sda & ~sda_pull;

  smb_alert_responder uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .start_det(start_det), .stop_det(stop_det), .alert_event(alert_event),
    .mode_en(mode_en), .sda_pull(sda_pull), .alert_out(alert_out)
  );

  int  checks = 0, fails = 0;
  bit  done = 0;
  logic e_armed = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [8:0] arb(input bit u_on, input bit c_on, input logic [6:0] ca);
    logic [7:0] ub = {DEV, 1'b1}, cb = {ca, 1'b1}, res;
    bit ua = u_on, cact = c_on;
    for (int i = 7; i >= 0; i--) begin
      logic l;
      l = (ua ? ub[i] : 1'b1) & (cact ? cb[i] : 1'b1);
      if (ua && ub[i] && !l) ua = 0;
      if (cact && cb[i] && !l) cact = 0;
      res[i] = l;
    end
    return {u_on && ua, res};
  endfunction

  task automatic do_start;
    sda_m = 1; scl = 1; hclk(HP);
    sda_m = 0; start_det = 1; hclk(1); start_det = 0;
    hclk(HP); scl = 0; hclk(HP);
  endtask

  task automatic do_stop;
    scl = 0; sda_m = 0; comp_sda = 1; hclk(HP);
    scl = 1; hclk(HP);
    sda_m = 1; stop_det = 1; hclk(1); stop_det = 0; hclk(HP);
  endtask

  task automatic clk_bit(input logic m, output logic r);
    sda_m = m; hclk(HP);
    scl = 1; hclk(HP / 2);
    r = sda_line; hclk(HP / 2);
    scl = 0; hclk(2);
  endtask

  task automatic pulse_event;
    alert_event = 1; hclk(1); alert_event = 0; hclk(2);
  endtask

  task automatic ara(input logic [7:0] first, input logic mack, input bit c_on,
                     input logic [6:0] ca, input int cut, input bit ev_mid,
                     output bit acked, output logic [7:0] rb, output logic ack9,
                     output logic al_pre);
    logic r;
    logic [7:0] cb = {ca, 1'b1};
    bit cact = c_on;
    acked = 0; rb = 8'hFF; ack9 = 1; al_pre = alert_out;
    do_start;
    for (int i = 0; i < 8; i++) begin
      if (cut == i) begin do_stop; return; end
      clk_bit(first[7-i], r);
    end
    comp_sda = c_on ? 1'b0 : 1'b1;
    clk_bit(1'b1, r);
    acked = !r;
    comp_sda = 1;
    if (first[0]) begin
      for (int i = 0; i < 8; i++) begin
        if (cut == 8 + i) begin do_stop; return; end
        if (ev_mid && i == 4) pulse_event;
        comp_sda = cact ? cb[7-i] : 1'b1;
        clk_bit(1'b1, r);
        if (cact && cb[7-i] && !r) cact = 0;
        rb[7-i] = r;
      end
      comp_sda = 1;
      clk_bit(mack, r);
      ack9 = r;
    end
    al_pre = alert_out;
    do_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit acked;
    logic [7:0] rb;
    logic ack9, alp;
    logic [8:0] ex;
    void'($urandom(32'd7));
    rst_n = 0; scl = 1; sda_m = 1; comp_sda = 1; start_det = 0; stop_det = 0;
    alert_event = 0; mode_en = 1;
    hclk(5); rst_n = 1; hclk(3);
    chk("R1 reset sda_pull", sda_pull, 0);
    chk("R1 reset alert_out", alert_out, 0);

    ara(8'h19, 1, 0, 7'h0, 99, 0, acked, rb, ack9, alp);
    chk("R2 disarmed no ack", acked, 0);
    chk("R2 disarmed byte", rb, 8'hFF);

    pulse_event;
    chk("R1 event arms", alert_out, 1);
    mode_en = 0; hclk(2);
    chk("R1 mode off hides alert", alert_out, 0);
    ara(8'h19, 1, 0, 7'h0, 99, 0, acked, rb, ack9, alp);
    chk("R2 mode off no ack", acked, 0);
    mode_en = 1; hclk(2);
    chk("R1 mode on alert", alert_out, 1);

    ara(8'h18, 1, 0, 7'h0, 99, 0, acked, rb, ack9, alp);
    chk("R2 write bit no ack", acked, 0);
    chk("R2 alert kept", alert_out, 1);

    ara(8'h19, 1, 1, 7'h10, 99, 0, acked, rb, ack9, alp);
    chk("R4 lower competitor wins", rb, 8'h21);
    chk("R5 loser keeps alert", alert_out, 1);

    ara(8'h19, 1, 1, 7'h70, 99, 0, acked, rb, ack9, alp);
    chk("R3 response byte", rb, 8'hC9);
    chk("R9 host nak line", ack9, 1);
    chk("R6 winner clears alert", alert_out, 0);
    ara(8'h19, 1, 0, 7'h0, 99, 0, acked, rb, ack9, alp);
    chk("R6 no ack after win", acked, 0);

    pulse_event;
    ara(8'h19, 1, 0, 7'h0, 3, 0, acked, rb, ack9, alp);
    chk("R8 stop in address keeps alert", alert_out, 1);
    chk("R8 line released", sda_line, 1);
    ara(8'h19, 1, 0, 7'h0, 11, 0, acked, rb, ack9, alp);
    chk("R8 stop in response keeps alert", alert_out, 1);
    chk("R8 released after stop", sda_line, 1);
    ara(8'h19, 0, 0, 7'h0, 99, 0, acked, rb, ack9, alp);
    chk("R5 retry ack", acked, 1);
    chk("R3 retry byte", rb, 8'hC9);
    chk("R9 host ack ignored", alert_out, 0);

    pulse_event;
    ara(8'h19, 1, 0, 7'h0, 99, 1, acked, rb, ack9, alp);
    chk("R7 byte with mid event", rb, 8'hC9);
    chk("R7 disarmed before stop", alp, 0);
    chk("R7 rearmed at stop", alert_out, 1);
    e_armed = 1;

    for (int n = 0; n < 40; n++) begin
      logic [7:0] first;
      logic [6:0] ca;
      int sel;
      bit c_on, u_on;
      logic mack;
      if ($urandom_range(0, 1) == 1) begin pulse_event; e_armed = 1; end
      mode_en = ($urandom_range(0, 3) != 0);
      hclk(2);
      sel = $urandom_range(0, 3);
      first = (sel == 0) ? 8'h18 : (sel == 3) ? 8'($urandom) : 8'h19;
      c_on = (first == 8'h19) && ($urandom_range(0, 1) == 1);
      ca = 7'($urandom);
      if (ca == DEV) ca = ca ^ 7'h01;
      mack = 1'($urandom);
      u_on = (first == 8'h19) && e_armed && mode_en;
      ex = arb(u_on, c_on, ca);
      ara(first, mack, c_on, ca, 99, 0, acked, rb, ack9, alp);
      chk("R2 random ack", acked, u_on || c_on);
      if (first[0]) chk("R4 random byte", rb, ex[7:0]);
      if (first[0] && mack) chk("R9 random ninth bit", ack9, 1);
      if (ex[8]) e_armed = 0;
      chk("R6 random alert", alert_out, e_armed && mode_en);
    end
    mode_en = 1;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule